// File: doc/BRIEF.md
# Criticality-Aware Bank Request Scheduler

This block schedules the requests of a single memory bank run under an open-page policy. The last-level cache pushes block fetches and block writebacks into a small per-bank queue. Each request gets a cycle-timed sequence of commands. A request that targets the row already held in the row buffer needs only a column access. A request to another row first writes the held row back to the array, then opens the new row, then does the column access.

The speed of the write-back that closes a row is chosen for each miss. The choice depends on the request that caused the miss. A writeback does not stall the processor, so it closes the row with the slow, low-energy write. A fetch is on the critical path, so it closes the row with the fast write. Fetches may overtake queued writebacks, but never one with the same block address. A control input turns reordering off, and the queue is then served strictly in arrival order.

Each phase is timed by a down-counter. The open, column, fast-close and slow-close durations are parameters in cycles. Completion of each request is reported with its tag.

Top module: `crit_bank_sched`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid` and `done_valid` are 0. No row is open, so the first request issues an open (`cmd_kind` 2) and then a column (`cmd_kind` 3), with no close.
- R2: The queue holds `DEPTH` requests, with a default of 4 and a legal range of 2 to 64. While it holds `DEPTH` entries, `req_ready` is 0 and the occupancy does not grow. Stalled requests are accepted later and served.
- R3: A request whose row (`addr >> COL_W`) equals the open row issues only a column command.
- R4: A request to another row while a row is open issues a close, then an open of its own row, then a column, and then completes. The close command carries the row being closed.
- R5: The close uses close-slow (`cmd_kind` 1) when the missing request is a writeback (`req_is_wb`=1). It uses close-fast (`cmd_kind` 0) when the missing request is a fetch.
- R6: With `reorder_en`=1, the next request is the oldest fetch that has no older queued writeback with the same full address. The fetch's age decides, not whether it hits the open row. If no fetch qualifies, the oldest entry is served.
- R7: With `reorder_en`=1, a fetch is never served before an older queued writeback with an identical address.
- R8: With `reorder_en`=0, requests are served strictly in arrival order.
- R9: Each command is followed by the next event after a fixed number of cycles. After close-fast the gap is `T_FAST`. After close-slow it is `T_SLOW`. After open it is `T_OPEN`. After column it is `T_COL`, and that event is the completion.
- R10: `cmd_valid` and `done_valid` are one-cycle pulses. `done_tag` and `done_is_wb` return the tag and type of the served request. With requests waiting, the next request's first command follows its predecessor's completion by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reorder_en | input | 1 | 1: fetches may bypass writebacks; 0: arrival order |
| req_valid | input | 1 | Request offered |
| req_is_wb | input | 1 | 1 = writeback, 0 = fetch |
| req_addr | input | ADDR_W | Block address, row in the upper bits, column in the low COL_W bits |
| req_tag | input | TAG_W | Request identifier returned at completion |
| req_ready | output | 1 | Queue can accept a request this cycle |
| cmd_valid | output | 1 | Command pulse |
| cmd_kind | output | 2 | 0 close-fast, 1 close-slow, 2 open, 3 column |
| cmd_row | output | ADDR_W-COL_W | Row the command acts on |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |
| done_is_wb | output | 1 | Type of the completed request |

## Verification
The tests use four request mixes, and each one separates a different policy.

- Fetches mixed with writebacks to unrelated rows, including a fetch to the open row queued behind two writebacks. This shows that bypassing takes place and that hits and slow closes follow from it.
- A fetch queued behind a writeback with the same address, with a younger unrelated fetch behind both. This separates the address-match block from plain age order, and it separates the fast close from the slow close.
- The same style of mix with reordering off, which must reproduce arrival order exactly.
- A burst of writebacks that overfills the queue, which checks the stall at the enqueue port and shows that no stalled request is lost.

In every mix, each command and completion is compared for kind, row, tag and the cycle gap since the previous event.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   typedef enum logic [1:0] {
      CMD_CLOSE_FAST = 2'd0,
      CMD_CLOSE_SLOW = 2'd1,
      CMD_OPEN       = 2'd2,
      CMD_COLUMN     = 2'd3
   } cbs_cmd_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CLOSE,
      PH_OPEN,
      PH_COL
   } cbs_phase_e;
endpackage

// File: rtl/cbs_req_queue.sv
module cbs_req_queue #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 12,
   parameter int TAG_W  = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reorder_en,
   input  logic              enq_valid,
   input  logic              enq_is_wb,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [TAG_W-1:0]  enq_tag,
   output logic              enq_ready,
   input  logic              take,
   output logic              head_valid,
   output logic              head_is_wb,
   output logic [ADDR_W-1:0] head_addr,
   output logic [TAG_W-1:0]  head_tag,
   output logic [CNT_W-1:0]  occupancy
);
   // Entries are kept compacted: slot 0 is the oldest.
   logic [CNT_W-1:0]  cnt_q;
   logic [DEPTH-1:0]  wb_q;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [TAG_W-1:0]  tag_q  [DEPTH];

   logic [DEPTH-1:0]  eligible;
   logic [IDX_W-1:0]  sel;

   // Fetch eligibility: no older valid writeback with the same address.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic blocked;
      always_comb begin
         blocked = 1'b0;
         for (int j = 0; j < gi; j++) begin
            if (CNT_W'(j) < cnt_q && wb_q[j] && addr_q[j] == addr_q[gi])
               blocked = 1'b1;
         end
      end
      assign eligible[gi] = (CNT_W'(gi) < cnt_q) && !wb_q[gi] && !blocked;
   end

   always_comb begin
      logic found;
      found = 1'b0;
      sel   = '0;
      if (reorder_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (eligible[i] && !found) begin
               sel   = IDX_W'(i);
               found = 1'b1;
            end
         end
      end
   end

   assign enq_ready  = cnt_q < CNT_W'(DEPTH);
   assign head_valid = cnt_q != '0;
   assign head_is_wb = wb_q[sel];
   assign head_addr  = addr_q[sel];
   assign head_tag   = tag_q[sel];
   assign occupancy  = cnt_q;

   logic              rm, push;
   logic [CNT_W-1:0]  cnt_n, base;
   logic [DEPTH-1:0]  wb_n;
   logic [ADDR_W-1:0] addr_n [DEPTH];
   logic [TAG_W-1:0]  tag_n  [DEPTH];

   always_comb begin
      rm   = take && head_valid;
      push = enq_valid && enq_ready;
      base = cnt_q - CNT_W'(rm);
      for (int i = 0; i < DEPTH; i++) begin
         if (rm && IDX_W'(i) >= sel && i + 1 < DEPTH) begin
            wb_n[i]   = wb_q[i+1];
            addr_n[i] = addr_q[i+1];
            tag_n[i]  = tag_q[i+1];
         end else begin
            wb_n[i]   = wb_q[i];
            addr_n[i] = addr_q[i];
            tag_n[i]  = tag_q[i];
         end
         if (push && CNT_W'(i) == base) begin
            wb_n[i]   = enq_is_wb;
            addr_n[i] = enq_addr;
            tag_n[i]  = enq_tag;
         end
      end
      cnt_n = base + CNT_W'(push);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         wb_q  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= '0;
            tag_q[i]  <= '0;
         end
      end else begin
         cnt_q <= cnt_n;
         wb_q  <= wb_n;
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= addr_n[i];
            tag_q[i]  <= tag_n[i];
         end
      end
   end
endmodule

// File: rtl/cbs_phase_seq.sv
module cbs_phase_seq
   import cbs_pkg::*;
#(
   parameter int ROW_W  = 8,
   parameter int TAG_W  = 4,
   parameter int T_OPEN = 30,
   parameter int T_COL  = 16,
   parameter int T_FAST = 9,
   parameter int T_SLOW = 166
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_valid,
   input  logic             head_is_wb,
   input  logic [ROW_W-1:0] head_row,
   input  logic [TAG_W-1:0] head_tag,
   output logic             take,
   output logic             cmd_valid,
   output cbs_cmd_e         cmd_kind,
   output logic [ROW_W-1:0] cmd_row,
   output logic             done_valid,
   output logic [TAG_W-1:0] done_tag,
   output logic             done_is_wb
);
   localparam int T_MAX01 = (T_OPEN > T_COL) ? T_OPEN : T_COL;
   localparam int T_MAX23 = (T_FAST > T_SLOW) ? T_FAST : T_SLOW;
   localparam int T_MAX   = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
   localparam int CT_W    = $clog2(T_MAX + 1);

   cbs_phase_e       phase;
   logic [CT_W-1:0]  cnt;
   logic             row_open;
   logic [ROW_W-1:0] open_row, cur_row;
   logic [TAG_W-1:0] cur_tag;
   logic             cur_wb;

   assign take = (phase == PH_IDLE) && head_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         row_open   <= 1'b0;
         open_row   <= '0;
         cur_row    <= '0;
         cur_tag    <= '0;
         cur_wb     <= 1'b0;
         cmd_valid  <= 1'b0;
         cmd_kind   <= CMD_OPEN;
         cmd_row    <= '0;
         done_valid <= 1'b0;
         done_tag   <= '0;
         done_is_wb <= 1'b0;
      end else begin
         cmd_valid  <= 1'b0;
         done_valid <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (head_valid) begin
                  cur_row   <= head_row;
                  cur_tag   <= head_tag;
                  cur_wb    <= head_is_wb;
                  cmd_valid <= 1'b1;
                  if (row_open && open_row == head_row) begin
                     phase    <= PH_COL;
                     cmd_kind <= CMD_COLUMN;
                     cmd_row  <= head_row;
                     cnt      <= CT_W'(T_COL - 1);
                  end else if (row_open) begin
                     phase    <= PH_CLOSE;
                     cmd_kind <= head_is_wb ? CMD_CLOSE_SLOW : CMD_CLOSE_FAST;
                     cmd_row  <= open_row;
                     cnt      <= head_is_wb ? CT_W'(T_SLOW - 1) : CT_W'(T_FAST - 1);
                  end else begin
                     phase    <= PH_OPEN;
                     cmd_kind <= CMD_OPEN;
                     cmd_row  <= head_row;
                     cnt      <= CT_W'(T_OPEN - 1);
                  end
               end
            end
            PH_CLOSE: begin
               if (cnt == '0) begin
                  phase     <= PH_OPEN;
                  row_open  <= 1'b0;
                  cmd_valid <= 1'b1;
                  cmd_kind  <= CMD_OPEN;
                  cmd_row   <= cur_row;
                  cnt       <= CT_W'(T_OPEN - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_OPEN: begin
               if (cnt == '0) begin
                  phase     <= PH_COL;
                  row_open  <= 1'b1;
                  open_row  <= cur_row;
                  cmd_valid <= 1'b1;
                  cmd_kind  <= CMD_COLUMN;
                  cmd_row   <= cur_row;
                  cnt       <= CT_W'(T_COL - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_COL: begin
               if (cnt == '0) begin
                  phase      <= PH_IDLE;
                  done_valid <= 1'b1;
                  done_tag   <= cur_tag;
                  done_is_wb <= cur_wb;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/crit_bank_sched.sv
module crit_bank_sched
   import cbs_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 12,
   parameter int COL_W  = 4,
   parameter int TAG_W  = 4,
   parameter int T_OPEN = 30,
   parameter int T_COL  = 16,
   parameter int T_FAST = 9,
   parameter int T_SLOW = 166,
   localparam int ROW_W = ADDR_W - COL_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reorder_en,
   input  logic              req_valid,
   input  logic              req_is_wb,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic [ROW_W-1:0]  cmd_row,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag,
   output logic              done_is_wb
);
   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("crit_bank_sched: DEPTH must lie in 2..64");
   end
   if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_split
      $error("crit_bank_sched: COL_W must leave at least one row bit");
   end
   if (T_OPEN < 1 || T_COL < 1 || T_FAST < 1 || T_SLOW < 1) begin : g_bad_time
      $error("crit_bank_sched: every phase needs at least one cycle");
   end

   logic              head_valid, head_is_wb, take;
   logic [ADDR_W-1:0] head_addr;
   logic [TAG_W-1:0]  head_tag;
   logic [CNT_W-1:0]  occupancy;
   cbs_cmd_e          kind_e;

   cbs_req_queue #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .TAG_W (TAG_W)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .reorder_en(reorder_en),
      .enq_valid (req_valid),
      .enq_is_wb (req_is_wb),
      .enq_addr  (req_addr),
      .enq_tag   (req_tag),
      .enq_ready (req_ready),
      .take      (take),
      .head_valid(head_valid),
      .head_is_wb(head_is_wb),
      .head_addr (head_addr),
      .head_tag  (head_tag),
      .occupancy (occupancy)
   );

   cbs_phase_seq #(
      .ROW_W (ROW_W),
      .TAG_W (TAG_W),
      .T_OPEN(T_OPEN),
      .T_COL (T_COL),
      .T_FAST(T_FAST),
      .T_SLOW(T_SLOW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .head_valid(head_valid),
      .head_is_wb(head_is_wb),
      .head_row  (head_addr[ADDR_W-1:COL_W]),
      .head_tag  (head_tag),
      .take      (take),
      .cmd_valid (cmd_valid),
      .cmd_kind  (kind_e),
      .cmd_row   (cmd_row),
      .done_valid(done_valid),
      .done_tag  (done_tag),
      .done_is_wb(done_is_wb)
   );

   assign cmd_kind = kind_e;
endmodule

// File: rtl/cbs_sched_chk.sv
module cbs_sched_chk #(
   parameter int T_OPEN = 30,
   parameter int T_COL  = 16,
   parameter int T_FAST = 9,
   parameter int T_SLOW = 166,
   parameter int CNT_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic [CNT_W-1:0] occ,
   input logic             cmd_valid,
   input logic [1:0]       cmd_kind,
   input logic             done_valid
);
   logic        seen;
   logic [1:0]  last_kind;
   logic [31:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen      <= 1'b0;
         last_kind <= 2'd0;
         gap       <= 32'd0;
      end else begin
         if (cmd_valid) begin
            seen      <= 1'b1;
            last_kind <= cmd_kind;
         end
         if (cmd_valid || done_valid) gap <= 32'd1;
         else                         gap <= gap + 32'd1;
      end
   end

   AST_FIRST_IS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !seen |-> cmd_kind == 2'd2);                                     // R1
   AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> occ <= $past(occ));                                             // R2
   AST_COL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_kind == 2'd3 && seen |-> last_kind == 2'd2 || last_kind == 2'd3); // R3
   AST_OPEN_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_kind == 2'd2 && seen |-> last_kind == 2'd0 || last_kind == 2'd1); // R4
   AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && seen && last_kind == 2'd1 |-> gap == T_SLOW);                     // R9
   AST_FAST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && seen && last_kind == 2'd0 |-> gap == T_FAST);                     // R9
   AST_DONE_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> seen && last_kind == 2'd3 && gap == T_COL);                     // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);                                                   // R10
endmodule

bind crit_bank_sched cbs_sched_chk #(
   .T_OPEN(T_OPEN),
   .T_COL (T_COL),
   .T_FAST(T_FAST),
   .T_SLOW(T_SLOW),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .occ       (occupancy),
   .cmd_valid (cmd_valid),
   .cmd_kind  (cmd_kind),
   .done_valid(done_valid)
);

// File: tb/crit_bank_sched_tb_top.sv
module crit_bank_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 4;
   localparam int ADDR_W = 12;
   localparam int COL_W  = 4;
   localparam int TAG_W  = 4;
   localparam int ROW_W  = ADDR_W - COL_W;
   localparam int T_OPEN = 30;
   localparam int T_COL  = 16;
   localparam int T_FAST = 9;
   localparam int T_SLOW = 166;
   localparam int EV_DONE = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reorder_en = 1'b1;
   logic              req_valid = 1'b0;
   logic              req_is_wb = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [TAG_W-1:0]  req_tag = '0;
   logic              req_ready;
   logic              cmd_valid;
   logic [1:0]        cmd_kind;
   logic [ROW_W-1:0]  cmd_row;
   logic              done_valid;
   logic [TAG_W-1:0]  done_tag;
   logic              done_is_wb;

   crit_bank_sched #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .COL_W(COL_W), .TAG_W(TAG_W),
      .T_OPEN(T_OPEN), .T_COL(T_COL), .T_FAST(T_FAST), .T_SLOW(T_SLOW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reorder_en(reorder_en),
      .req_valid(req_valid), .req_is_wb(req_is_wb), .req_addr(req_addr),
      .req_tag(req_tag), .req_ready(req_ready),
      .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row),
      .done_valid(done_valid), .done_tag(done_tag), .done_is_wb(done_is_wb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   int last_ev  = 0;
   bit finished = 1'b0;

   // scoreboard
   int    ev_kind[$];
   int    ev_val[$];
   int    ev_gap[$];
   string ev_req[$];

   // reference bank state
   bit model_open = 1'b0;
   int model_row  = 0;

   // scenario buffers
   int sc_wb[8];
   int sc_addr[8];
   int sc_n = 0;
   int tag_ctr = 1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push_ev(input int kind, input int val, input int gap, input string req);
      ev_kind.push_back(kind);
      ev_val.push_back(val);
      ev_gap.push_back(gap);
      ev_req.push_back(req);
   endtask

   // Expected events for serving one request, from the requirements.
   task automatic serve_model(input int wb, input int addr, input int tag, input int first_gap, input string tg);
      int row;
      row = addr >> COL_W;
      if (model_open && row == model_row) begin
         push_ev(3, row, first_gap, {tg, " R3 R10"});
      end else if (model_open) begin
         push_ev(wb ? 1 : 0, model_row, first_gap, {tg, " R4 R5 R10"});
         push_ev(2, row, wb ? T_SLOW : T_FAST, {tg, " R4 R9"});
         push_ev(3, row, T_OPEN, {tg, " R4 R9"});
      end else begin
         push_ev(2, row, first_gap, {tg, " R1"});
         push_ev(3, row, T_OPEN, {tg, " R1 R9"});
      end
      push_ev(EV_DONE, (wb << TAG_W) | tag, T_COL, {tg, " R9 R10"});
      model_open = 1'b1;
      model_row  = row;
   endtask

   task automatic add_req(input int wb, input int addr);
      sc_wb[sc_n]   = wb;
      sc_addr[sc_n] = addr;
      sc_n++;
   endtask

   task automatic enq(input int wb, input int addr, input int tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_is_wb = wb[0];
      req_addr  = ADDR_W'(addr);
      req_tag   = TAG_W'(tag);
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Build expected order (first served alone, rest by policy), then drive.
   task automatic run_scenario(input bit reord, input string tg);
      int tags[8];
      bit used[8];
      int left;
      reorder_en = reord;
      for (int i = 0; i < sc_n; i++) begin
         tags[i] = tag_ctr;
         tag_ctr = (tag_ctr % 15) + 1;
         used[i] = 1'b0;
      end
      serve_model(sc_wb[0], sc_addr[0], tags[0], 0, tg);
      used[0] = 1'b1;
      left = sc_n - 1;
      while (left > 0) begin
         int pick;
         pick = -1;
         if (reord) begin
            for (int i = 1; i < sc_n; i++) begin
               if (!used[i] && !sc_wb[i] && pick < 0) begin
                  bit blk;
                  blk = 1'b0;
                  for (int j = 1; j < i; j++)
                     if (!used[j] && sc_wb[j] && sc_addr[j] == sc_addr[i]) blk = 1'b1;
                  if (!blk) pick = i;
               end
            end
         end
         if (pick < 0) begin
            for (int i = 1; i < sc_n; i++)
               if (!used[i] && pick < 0) pick = i;
         end
         serve_model(sc_wb[pick], sc_addr[pick], tags[pick], 1, tg);
         used[pick] = 1'b1;
         left--;
      end
      for (int i = 0; i < sc_n; i++) enq(sc_wb[i], sc_addr[i], tags[i]);
      while (ev_kind.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      sc_n = 0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && (cmd_valid || done_valid)) begin
         int gap, k, v, g;
         string r;
         gap = cyc - last_ev;
         last_ev = cyc;
         if (ev_kind.size() == 0) begin
            check(1'b0, "R4", "unexpected event kind", cmd_valid ? int'(cmd_kind) : EV_DONE, -1);
         end else begin
            k = ev_kind.pop_front();
            v = ev_val.pop_front();
            g = ev_gap.pop_front();
            r = ev_req.pop_front();
            if (k == EV_DONE) begin
               check(done_valid && !cmd_valid, r, "completion expected, cmd_kind", int'(cmd_kind), k);
               check(((int'(done_is_wb) << TAG_W) | int'(done_tag)) == v, r, "done type/tag", (int'(done_is_wb) << TAG_W) | int'(done_tag), v);
            end else begin
               check(cmd_valid && int'(cmd_kind) == k, r, "cmd_kind", cmd_valid ? int'(cmd_kind) : EV_DONE, k);
               check(int'(cmd_row) == v, r, "cmd_row", int'(cmd_row), v);
            end
            if (g != 0) check(gap == g, r, "gap cycles", gap, g);
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
      check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
      check(done_valid == 1'b0, "R1", "done_valid after reset", int'(done_valid), 0);
      last_ev = cyc;

      // R6: fetch to open row bypasses two writebacks
      add_req(0, 'h010); add_req(1, 'h020); add_req(1, 'h030); add_req(0, 'h015);
      run_scenario(1'b1, "R6");

      // R7: fetch blocked by same-address writeback, younger fetch passes
      add_req(0, 'h060); add_req(1, 'h050); add_req(0, 'h050); add_req(0, 'h071);
      run_scenario(1'b1, "R7");

      // R8: reordering off keeps arrival order
      add_req(0, 'h080); add_req(1, 'h090); add_req(0, 'h0A0); add_req(0, 'h0A3);
      run_scenario(1'b0, "R8");

      // R2: overfill the queue
      for (int i = 0; i < DEPTH + 1; i++) begin
         serve_model(1, 'h100 + i * 'h10, tag_ctr, (i == 0) ? 0 : 1, "R2");
         enq(1, 'h100 + i * 'h10, tag_ctr);
         tag_ctr = (tag_ctr % 15) + 1;
      end
      @(negedge clk);
      check(req_ready == 1'b0, "R2", "req_ready with full queue", int'(req_ready), 0);
      serve_model(1, 'h1F0, tag_ctr, 1, "R2");
      enq(1, 'h1F0, tag_ctr);
      while (ev_kind.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      check(req_ready == 1'b1, "R2", "req_ready after drain", int'(req_ready), 1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule